// File: doc/BRIEF.md
# Eight-bit Arithmetic and Logic Unit with Four Condition Flags

This block is the purely combinational datapath core of a small 8-bit processor. Each cycle it takes a first operand (always a register), a second operand (a register or an immediate, as chosen upstream), a 3-bit count used by the shift, rotate and bit-test operations, a 4-bit operation code and the four incoming condition flags: zero (Z), carry (C), overflow (V) and sign (N). It returns an 8-bit result, a result write strobe and the four outgoing flags.

Every operation class owns a fixed subset of the flags. Flags outside that subset are copied from input to output unchanged, so the flag register upstream can be loaded from the outputs every cycle. Compare and bit-test only set flags: they leave the write strobe low and pass the first operand through on the result port. The block holds no state and has no state machine. It has no states or transitions. The result and flags follow the inputs within the same cycle.

Operation codes: 0 AND, 1 OR, 2 XOR, 3 INC, 4 DEC, 5 ADD, 6 SUB, 7 CMP, 8 SHL, 9 SHR, 10 ROL, 11 ROR, 12 BIT, and 13 to 15 unused.

Top module: `alu8_core`

## Requirements
- R1: Codes 0, 1 and 2 (AND, OR, XOR) drive the bitwise result of the two operands and raise the write strobe. They update Z and N. C and V are copied from the inputs.
- R2: For every code that raises the write strobe, Z is 1 exactly when the 8-bit result is zero, and N equals result bit 7.
- R3: Code 3 (INC) drives operand plus one and code 4 (DEC) drives operand minus one, with the write strobe high. Both C and V are 1 only on wrap-around: from 0xFF to 0x00 for INC, and from 0x00 to 0xFF for DEC.
- R4: Code 5 (ADD) drives the sum modulo 256 with the write strobe high. C is the unsigned carry out of bit 7. V is signed two's-complement overflow.
- R5: Code 6 (SUB) drives the first operand minus the second with the write strobe high. C is 1 on borrow (first operand below second, unsigned). V is signed two's-complement overflow.
- R6: Code 7 (CMP) sets Z, C, V and N exactly as SUB would. The write strobe stays low and the result port carries the first operand.
- R7: Codes 8 (SHL) and 9 (SHR) shift the first operand by the count (0 to 7), filling with zeros, with the write strobe high. C is the last bit shifted out, Z and N are updated, and V is copied from the input.
- R8: Codes 10 (ROL) and 11 (ROR) rotate the first operand by the count, with the write strobe high. C is the last bit rotated out, which equals result bit 0 for ROL and result bit 7 for ROR. Z and N are updated and V is copied from the input.
- R9: For codes 8 to 11, a count of 0 returns the operand unchanged and clears C.
- R10: Code 12 (BIT) sets Z to bit n of the first operand, where n is the count. The write strobe stays low, the result port carries the first operand, and C, V and N are copied from the inputs.
- R11: Codes 13 to 15 leave the write strobe low, pass the first operand to the result port and copy all four flags from the inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 4 | Operation code |
| opa_i | input | 8 | First operand (register) |
| opb_i | input | 8 | Second operand (register or immediate) |
| cnt_i | input | 3 | Shift, rotate or bit index count |
| zf_i | input | 1 | Incoming zero flag |
| cf_i | input | 1 | Incoming carry flag |
| of_i | input | 1 | Incoming overflow flag |
| sf_i | input | 1 | Incoming sign flag |
| result_o | output | 8 | Result value |
| wr_en_o | output | 1 | Result write strobe |
| zf_o | output | 1 | Outgoing zero flag |
| cf_o | output | 1 | Outgoing carry flag |
| of_o | output | 1 | Outgoing overflow flag |
| sf_o | output | 1 | Outgoing sign flag |

## Verification
No register sits between the inputs and the outputs, so every result, strobe and flag is due in the same cycle its inputs are applied. The driver applies each vector on a rising edge and queues the expected outputs at the same moment. The monitor compares on the following falling edge, half a period later, when the outputs have long settled and no edge is near. Only one vector is in flight at a time, so the queue order matches the order of the outputs.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

    typedef enum logic [3:0] {
        OP_AND = 4'd0,
        OP_OR  = 4'd1,
        OP_XOR = 4'd2,
        OP_INC = 4'd3,
        OP_DEC = 4'd4,
        OP_ADD = 4'd5,
        OP_SUB = 4'd6,
        OP_CMP = 4'd7,
        OP_SHL = 4'd8,
        OP_SHR = 4'd9,
        OP_ROL = 4'd10,
        OP_ROR = 4'd11,
        OP_BIT = 4'd12
    } alu_op_e;

    typedef enum logic [1:0] {
        LG_AND = 2'd0,
        LG_OR  = 2'd1,
        LG_XOR = 2'd2
    } logic_sel_e;

    typedef enum logic [1:0] {
        AR_INC = 2'd0,
        AR_DEC = 2'd1,
        AR_ADD = 2'd2,
        AR_SUB = 2'd3
    } arith_sel_e;

    typedef enum logic [1:0] {
        SH_LEFT  = 2'd0,
        SH_RIGHT = 2'd1,
        RO_LEFT  = 2'd2,
        RO_RIGHT = 2'd3
    } move_sel_e;

endpackage

// File: rtl/alu8_logic.sv
module alu8_logic
    import alu8_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic_sel_e       sel_i,
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    output logic [WIDTH-1:0] res_o
);
    always_comb begin
        unique case (sel_i)
            LG_AND:  res_o = a_i & b_i;
            LG_OR:   res_o = a_i | b_i;
            LG_XOR:  res_o = a_i ^ b_i;
            default: res_o = a_i;
        endcase
    end
endmodule

// File: rtl/alu8_arith.sv
module alu8_arith
    import alu8_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  arith_sel_e       sel_i,
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    output logic [WIDTH-1:0] res_o,
    output logic             c_o,
    output logic             v_o
);
    localparam int MSB = WIDTH - 1;

    logic [WIDTH-1:0] opnd;
    logic [WIDTH:0]   wide;
    logic             is_sub;
    logic             is_step;

    always_comb begin
        is_step = (sel_i == AR_INC) || (sel_i == AR_DEC);
        is_sub  = (sel_i == AR_DEC) || (sel_i == AR_SUB);
        opnd    = is_step ? WIDTH'(1) : b_i;
        if (is_sub) begin
            wide = {1'b0, a_i} - {1'b0, opnd};
        end else begin
            wide = {1'b0, a_i} + {1'b0, opnd};
        end
        res_o = wide[WIDTH-1:0];
        c_o   = wide[WIDTH];
        if (is_step) begin
            v_o = wide[WIDTH];
        end else if (is_sub) begin
            v_o = (a_i[MSB] != opnd[MSB]) && (res_o[MSB] != a_i[MSB]);
        end else begin
            v_o = (a_i[MSB] == opnd[MSB]) && (res_o[MSB] != a_i[MSB]);
        end
    end
endmodule

// File: rtl/alu8_shift.sv
module alu8_shift
    import alu8_pkg::*;
#(
    parameter int WIDTH = 8,
    parameter int CNT_W = $clog2(WIDTH)
) (
    input  move_sel_e        sel_i,
    input  logic [WIDTH-1:0] a_i,
    input  logic [CNT_W-1:0] n_i,
    output logic [WIDTH-1:0] res_o,
    output logic             c_o
);
    localparam int DW = 2 * WIDTH;

    logic [WIDTH:0] shl_w;
    logic [WIDTH:0] shr_w;
    logic [DW-1:0]  rol_w;
    logic [DW-1:0]  ror_w;
    logic           nz;

    always_comb begin
        nz    = (n_i != '0);
        shl_w = {1'b0, a_i} << n_i;
        shr_w = {a_i, 1'b0} >> n_i;
        rol_w = {a_i, a_i} << n_i;
        ror_w = {a_i, a_i} >> n_i;
        unique case (sel_i)
            SH_LEFT: begin
                res_o = shl_w[WIDTH-1:0];
                c_o   = shl_w[WIDTH];
            end
            SH_RIGHT: begin
                res_o = shr_w[WIDTH:1];
                c_o   = shr_w[0];
            end
            RO_LEFT: begin
                res_o = rol_w[DW-1:WIDTH];
                c_o   = nz & res_o[0];
            end
            default: begin
                res_o = ror_w[WIDTH-1:0];
                c_o   = nz & res_o[WIDTH-1];
            end
        endcase
    end
endmodule

// File: rtl/alu8_core.sv
module alu8_core
    import alu8_pkg::*;
#(
    parameter int WIDTH = 8,
    parameter int OP_W  = 4,
    parameter int CNT_W = $clog2(WIDTH)
) (
    input  logic [OP_W-1:0]  op_i,
    input  logic [WIDTH-1:0] opa_i,
    input  logic [WIDTH-1:0] opb_i,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic             zf_i,
    input  logic             cf_i,
    input  logic             of_i,
    input  logic             sf_i,
    output logic [WIDTH-1:0] result_o,
    output logic             wr_en_o,
    output logic             zf_o,
    output logic             cf_o,
    output logic             of_o,
    output logic             sf_o
);
    localparam int MSB = WIDTH - 1;

    logic_sel_e       lg_sel;
    arith_sel_e       ar_sel;
    move_sel_e        mv_sel;
    logic [WIDTH-1:0] lg_res;
    logic [WIDTH-1:0] ar_res;
    logic [WIDTH-1:0] mv_res;
    logic             ar_c;
    logic             ar_v;
    logic             mv_c;

    always_comb begin
        lg_sel = logic_sel_e'(op_i[1:0]);
        unique case (op_i)
            OP_INC:  ar_sel = AR_INC;
            OP_DEC:  ar_sel = AR_DEC;
            OP_ADD:  ar_sel = AR_ADD;
            default: ar_sel = AR_SUB;
        endcase
        mv_sel = move_sel_e'(op_i[1:0]);
    end

    alu8_logic #(.WIDTH(WIDTH)) u_logic (
        .sel_i (lg_sel),
        .a_i   (opa_i),
        .b_i   (opb_i),
        .res_o (lg_res)
    );

    alu8_arith #(.WIDTH(WIDTH)) u_arith (
        .sel_i (ar_sel),
        .a_i   (opa_i),
        .b_i   (opb_i),
        .res_o (ar_res),
        .c_o   (ar_c),
        .v_o   (ar_v)
    );

    alu8_shift #(.WIDTH(WIDTH), .CNT_W(CNT_W)) u_shift (
        .sel_i (mv_sel),
        .a_i   (opa_i),
        .n_i   (cnt_i),
        .res_o (mv_res),
        .c_o   (mv_c)
    );

    always_comb begin
        result_o = opa_i;
        wr_en_o  = 1'b0;
        zf_o     = zf_i;
        cf_o     = cf_i;
        of_o     = of_i;
        sf_o     = sf_i;
        case (op_i)
            OP_AND, OP_OR, OP_XOR: begin
                result_o = lg_res;
                wr_en_o  = 1'b1;
                zf_o     = (lg_res == '0);
                sf_o     = lg_res[MSB];
            end
            OP_INC, OP_DEC, OP_ADD, OP_SUB: begin
                result_o = ar_res;
                wr_en_o  = 1'b1;
                zf_o     = (ar_res == '0);
                cf_o     = ar_c;
                of_o     = ar_v;
                sf_o     = ar_res[MSB];
            end
            OP_CMP: begin
                zf_o = (ar_res == '0);
                cf_o = ar_c;
                of_o = ar_v;
                sf_o = ar_res[MSB];
            end
            OP_SHL, OP_SHR, OP_ROL, OP_ROR: begin
                result_o = mv_res;
                wr_en_o  = 1'b1;
                zf_o     = (mv_res == '0);
                cf_o     = mv_c;
                sf_o     = mv_res[MSB];
            end
            OP_BIT: begin
                zf_o = opa_i[cnt_i];
            end
            default: begin
            end
        endcase
    end

    always_comb begin
        if (wr_en_o) begin
            assert_zero_tracks_R2: assert (zf_o == (result_o == '0));
            assert_sign_tracks_R2: assert (sf_o == result_o[MSB]);
        end
        if (op_i == OP_AND || op_i == OP_OR || op_i == OP_XOR) begin
            assert_logic_keeps_cv_R1: assert (cf_o == cf_i && of_o == of_i);
        end
        if (op_i == OP_INC || op_i == OP_DEC) begin
            assert_step_wrap_R3: assert (of_o == cf_o);
        end
        if (op_i == OP_CMP) begin
            assert_cmp_no_write_R6: assert (!wr_en_o && result_o == opa_i);
        end
        if (op_i >= OP_SHL && op_i <= OP_ROR) begin
            assert_move_keeps_v_R7: assert (of_o == of_i);
            if (cnt_i == '0) begin
                assert_zero_count_R9: assert (result_o == opa_i && !cf_o);
            end
        end
        if (op_i == OP_ROL) begin
            assert_rol_carry_R8: assert (cnt_i == '0 || cf_o == result_o[0]);
        end
        if (op_i == OP_BIT) begin
            assert_bit_only_z_R10: assert (!wr_en_o && cf_o == cf_i && of_o == of_i && sf_o == sf_i);
        end
        if (op_i > OP_BIT) begin
            assert_unused_idle_R11: assert (!wr_en_o && zf_o == zf_i && cf_o == cf_i && of_o == of_i && sf_o == sf_i);
        end
    end
endmodule

// File: tb/alu8_core_tb.sv
`timescale 1ns/100ps
module alu8_core_tb;

    typedef struct {
        logic [3:0] op;
        logic [2:0] n;
        logic [7:0] res;
        logic       wr;
        logic [3:0] flg;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] op_i = '0;
    logic [7:0] opa_i = '0;
    logic [7:0] opb_i = '0;
    logic [2:0] cnt_i = '0;
    logic       zf_i = 1'b0, cf_i = 1'b0, of_i = 1'b0, sf_i = 1'b0;
    logic [7:0] result_o;
    logic       wr_en_o, zf_o, cf_o, of_o, sf_o;

    int   checks = 0;
    int   errors = 0;
    int   cycles = 0;
    exp_t q[$];

    always #2.5 clk = ~clk;

    alu8_core u_dut (
        .op_i(op_i), .opa_i(opa_i), .opb_i(opb_i), .cnt_i(cnt_i),
        .zf_i(zf_i), .cf_i(cf_i), .of_i(of_i), .sf_i(sf_i),
        .result_o(result_o), .wr_en_o(wr_en_o),
        .zf_o(zf_o), .cf_o(cf_o), .of_o(of_o), .sf_o(sf_o)
    );

    function automatic string tag(input logic [3:0] op, input logic [2:0] n);
        if (op <= 4'd2)  return "R1 R2";
        if (op <= 4'd4)  return "R3 R2";
        if (op == 4'd5)  return "R4 R2";
        if (op == 4'd6)  return "R5 R2";
        if (op == 4'd7)  return "R6";
        if (op <= 4'd11 && n == 3'd0) return "R9";
        if (op <= 4'd9)  return "R7 R2";
        if (op <= 4'd11) return "R8 R2";
        if (op == 4'd12) return "R10";
        return "R11";
    endfunction

    // flags packed as {Z,C,V,N}
    function automatic exp_t model(input logic [3:0] op, input logic [7:0] a,
                                   input logic [7:0] b, input logic [2:0] n,
                                   input logic [3:0] fin);
        exp_t e;
        logic z, c, v, s, upd;
        logic [7:0] r;
        {z, c, v, s} = fin;
        r = a;
        upd = 1'b0;
        e.wr = 1'b0;
        case (op)
            4'd0, 4'd1, 4'd2: begin
                r = (op == 4'd0) ? (a & b) : (op == 4'd1) ? (a | b) : (a ^ b);
                e.wr = 1'b1; upd = 1'b1;
            end
            4'd3: begin r = a + 8'd1; c = (a == 8'hFF); v = c; e.wr = 1'b1; upd = 1'b1; end
            4'd4: begin r = a - 8'd1; c = (a == 8'h00); v = c; e.wr = 1'b1; upd = 1'b1; end
            4'd5: begin
                r = a + b; c = (int'(a) + int'(b)) > 255;
                v = (a[7] == b[7]) && (r[7] != a[7]);
                e.wr = 1'b1; upd = 1'b1;
            end
            4'd6, 4'd7: begin
                r = a - b; c = (a < b);
                v = (a[7] != b[7]) && (r[7] != a[7]);
                e.wr = (op == 4'd6); upd = 1'b1;
            end
            4'd8, 4'd9, 4'd10, 4'd11: begin
                c = 1'b0;
                for (int i = 0; i < int'(n); i++) begin
                    case (op)
                        4'd8:  begin c = r[7]; r = {r[6:0], 1'b0}; end
                        4'd9:  begin c = r[0]; r = {1'b0, r[7:1]}; end
                        4'd10: begin c = r[7]; r = {r[6:0], r[7]}; end
                        default: begin c = r[0]; r = {r[0], r[7:1]}; end
                    endcase
                end
                e.wr = 1'b1; upd = 1'b1;
            end
            4'd12: z = a[n];
            default: ;
        endcase
        if (upd) begin z = (r == 8'h00); s = r[7]; end
        e.res = e.wr ? r : a;
        e.flg = {z, c, v, s};
        e.op = op;
        e.n = n;
        return e;
    endfunction

    task automatic drive(input logic [3:0] op, input logic [7:0] a, input logic [7:0] b,
                         input logic [2:0] n, input logic [3:0] fin);
        @(posedge clk);
        op_i = op; opa_i = a; opb_i = b; cnt_i = n;
        {zf_i, cf_i, of_i, sf_i} = fin;
        q.push_back(model(op, a, b, n, fin));
    endtask

    always @(negedge clk) begin
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            checks++;
            if (result_o !== e.res || wr_en_o !== e.wr ||
                {zf_o, cf_o, of_o, sf_o} !== e.flg) begin
                errors++;
                $display("FAIL %s op=%0d a=%h b=%h n=%0d got res=%h wr=%b zcvn=%b exp res=%h wr=%b zcvn=%b",
                         tag(e.op, e.n), e.op, opa_i, opb_i, e.n, result_o, wr_en_o,
                         {zf_o, cf_o, of_o, sf_o}, e.res, e.wr, e.flg);
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        rst = 1'b0;
        drive(4'd0, 8'h00, 8'h00, 3'd0, 4'b0000);   // idle state: AND of zeros
        // R1 logic ops, C and V kept
        drive(4'd0, 8'hF0, 8'h3C, 3'd0, 4'b0110);
        drive(4'd1, 8'h80, 8'h01, 3'd0, 4'b0100);
        drive(4'd2, 8'h5A, 8'h5A, 3'd0, 4'b0010);
        // R3 wrap cases and non-wrap
        drive(4'd3, 8'hFF, 8'h00, 3'd0, 4'b0000);
        drive(4'd3, 8'h7F, 8'h00, 3'd0, 4'b1111);
        drive(4'd4, 8'h00, 8'h00, 3'd0, 4'b0000);
        drive(4'd4, 8'h80, 8'h00, 3'd0, 4'b0110);
        // R4
        drive(4'd5, 8'h7F, 8'h01, 3'd0, 4'b0000);
        drive(4'd5, 8'hFF, 8'h01, 3'd0, 4'b0000);
        drive(4'd5, 8'h80, 8'h80, 3'd0, 4'b0000);
        // R5
        drive(4'd6, 8'h00, 8'h01, 3'd0, 4'b0000);
        drive(4'd6, 8'h80, 8'h01, 3'd0, 4'b0000);
        // R6
        drive(4'd7, 8'h42, 8'h42, 3'd0, 4'b0111);
        drive(4'd7, 8'h10, 8'h20, 3'd0, 4'b0000);
        // R7
        drive(4'd8, 8'h81, 8'h00, 3'd1, 4'b0010);
        drive(4'd9, 8'h01, 8'h00, 3'd1, 4'b0001);
        drive(4'd8, 8'h01, 8'h00, 3'd7, 4'b0000);
        // R8
        drive(4'd10, 8'h80, 8'h00, 3'd1, 4'b0000);
        drive(4'd11, 8'h01, 8'h00, 3'd7, 4'b0000);
        drive(4'd11, 8'h02, 8'h00, 3'd1, 4'b0100);
        // R9 count zero clears carry
        for (int k = 8; k <= 11; k++) drive(4'(k), 8'hA5, 8'h00, 3'd0, 4'b0110);
        // R10
        drive(4'd12, 8'h08, 8'h00, 3'd3, 4'b0111);
        drive(4'd12, 8'hF7, 8'h00, 3'd3, 4'b1000);
        // R11
        for (int k = 13; k <= 15; k++) drive(4'(k), 8'h3C, 8'hC3, 3'd5, 4'(k));
        // broad sweep over all codes
        for (int k = 0; k < 600; k++) begin
            drive(4'($urandom), 8'($urandom), 8'($urandom), 3'($urandom), 4'($urandom));
        end
        @(posedge clk);
        @(posedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule